// File: doc/BRIEF.md
# Serial Engine Run-State Controller

This block holds the operating state of a serial engine and presents it, with a set of operational flags, through a small register port. Software moves the engine between three states: reset, run and pause. A state request does not take effect at once. The block first counts a fixed number of interface-clock cycles. It then counts a fixed number of serial-master-clock ticks. During that window the valid flag in the state register stays low, and the new state shows only when valid comes back.

The serial master clock is modelled as an enable strobe, `ser_tick`, in the same clock domain as the register port. A software-reset register forces the engine back to the reset state at any time and clears its flags. A master-generator enable bit is read back through the state register.

The data path signals events into the block: a NACK, FIFO service requests and transfer-done markers. These set sticky flags. The two service flags are cleared by writing 1 to their bits. Three FIFO level indications appear one cycle late, and they are masked while the engine is in the reset state.

Top module: `sereng_state_ctl`

## Requirements
- R1: After hardware reset the state register reads 0x4: state code 0 (reset), valid (bit 2) set, master-generator bit 4 clear. The operational-flag register reads 0.
- R2: The state register carries the state code in bits [1:0]: 0 means reset, 1 means run and 3 means pause. A write of code 2 is ignored, and the register keeps reading its old value.
- R3: After a state write is accepted on clock edge k, valid reads 0 and the old code stays visible. This lasts for IF_CYC further clock edges and then until SER_CYC further edges with `ser_tick` high. On that last edge the new code appears with valid set. Ticks that arrive during the interface-clock phase do not count.
- R4: Writing a 1 to bit 0 of the software-reset register (address 1) works as follows. On the next edge the state becomes 0 with valid clear, the master-generator bit clears, all flags clear and any pending transition is abandoned. Valid then returns after the same latency as in R3.
- R5: Event inputs set sticky flags in the operational register (address 2) one edge later. The bit positions are: NACK at bit 3, output service at bit 8, input service at bit 9, output done at bit 10 and input done at bit 11.
- R6: Writing 1 to bit 8 or bit 9 of the operational register clears that service flag. Written ones in other positions have no effect. An event arriving on the same edge as the clear keeps its flag set.
- R7: Output-not-empty (bit 4), input-not-empty (bit 5) and output-full (bit 6) report the level inputs as they were sampled on the previous edge. They read 0 while the state code is 0.
- R8: A state write made while valid is low is ignored. The running transition ends in the state first requested.
- R9: Writing to the master-generator register (address 3) loads bit 0 of the data into state-register bit 4 on the next edge.
- R10: Reads are combinational on the address. Addresses with no register read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | AW | Register word address |
| reg_wdata | input | DW | Write data |
| reg_rdata | output | DW | Read data for reg_addr |
| ser_tick | input | 1 | One-cycle enable standing for a serial-master-clock edge |
| nack_evt | input | 1 | NACK event pulse |
| out_svc_evt | input | 1 | Output FIFO service request pulse |
| in_svc_evt | input | 1 | Input FIFO service request pulse |
| out_done_evt | input | 1 | Output transfer done pulse |
| in_done_evt | input | 1 | Input transfer done pulse |
| out_nempty_lvl | input | 1 | Output FIFO not empty level |
| in_nempty_lvl | input | 1 | Input FIFO not empty level |
| out_full_lvl | input | 1 | Output FIFO full level |

## Verification
Register writes, events and levels show in read data one edge after the edge that captures them. The bench drives on the falling edge and reads half a cycle later. It therefore checks each such result at the first falling edge after the capturing edge. For a state transition the bench keeps its own count of edges after the accepting edge. During the first IF_CYC edges it expects valid low. After that it counts only the edges on which it drove `ser_tick` high. It expects the new code at exactly the SER_CYC-th such edge and checks valid low on every edge before. The same counting covers software reset, where valid returns IF_CYC+SER_CYC edges later with the tick held high.

// File: rtl/sereng_pkg.sv
package sereng_pkg;

  localparam logic [1:0] ST_RESET = 2'd0;
  localparam logic [1:0] ST_RUN   = 2'd1;
  localparam logic [1:0] ST_PAUSE = 2'd3;

  localparam int STB_VALID = 2;
  localparam int STB_MGEN  = 4;

  localparam int FLB_NACK  = 3;
  localparam int FLB_ONE   = 4;
  localparam int FLB_INE   = 5;
  localparam int FLB_OFULL = 6;
  localparam int FLB_OSVC  = 8;
  localparam int FLB_ISVC  = 9;
  localparam int FLB_ODONE = 10;
  localparam int FLB_IDONE = 11;

  typedef enum logic [1:0] {PH_IDLE = 2'd0, PH_IFACE = 2'd1, PH_SERIAL = 2'd2} phase_e;

  function automatic logic code_is_legal(input logic [1:0] code);
    return code != 2'd2;
  endfunction

  function automatic logic cnt_at_end(input int unsigned cnt, input int unsigned limit);
    return cnt == limit - 1;
  endfunction

endpackage

// File: rtl/sereng_state_seq.sv
module sereng_state_seq
  import sereng_pkg::*;
#(
  parameter int IF_CYC  = 3,
  parameter int SER_CYC = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_wr,
  input  logic [1:0] req_code,
  input  logic       swrst,
  input  logic       ser_tick,
  output logic [1:0] state_o,
  output logic       valid_o
);

  localparam int MAXC  = (IF_CYC > SER_CYC) ? IF_CYC : SER_CYC;
  localparam int CNT_W = $clog2(MAXC) + 1;

  logic [1:0]       state_q, tgt_q;
  logic             valid_q;
  phase_e           phase_q;
  logic [CNT_W-1:0] cnt_q;
  logic             accept;
  logic             if_last, ser_last;

  assign accept   = req_wr && valid_q && code_is_legal(req_code) && !swrst;
  assign if_last  = cnt_at_end(int'(cnt_q), IF_CYC);
  assign ser_last = cnt_at_end(int'(cnt_q), SER_CYC);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_RESET;
      tgt_q   <= ST_RESET;
      valid_q <= 1'b1;
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
    end else if (swrst) begin
      state_q <= ST_RESET;
      tgt_q   <= ST_RESET;
      valid_q <= 1'b0;
      phase_q <= PH_IFACE;
      cnt_q   <= '0;
    end else begin
      case (phase_q)
        PH_IDLE: begin
          if (accept) begin
            tgt_q   <= req_code;
            valid_q <= 1'b0;
            phase_q <= PH_IFACE;
            cnt_q   <= '0;
          end
        end
        PH_IFACE: begin
          if (if_last) begin
            phase_q <= PH_SERIAL;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        PH_SERIAL: begin
          if (ser_tick) begin
            if (ser_last) begin
              state_q <= tgt_q;
              valid_q <= 1'b1;
              phase_q <= PH_IDLE;
              cnt_q   <= '0;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  assign state_o = state_q;
  assign valid_o = valid_q;

  a_r2_legal_code: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |-> code_is_legal(state_q));
  a_r3_low_window: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(valid_q) |=> !valid_q);
  a_r3_tick_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_SERIAL && !ser_tick && !swrst) |=> (phase_q == PH_SERIAL && $stable(cnt_q) && !valid_q));
  a_r4_swrst: assert property (@(posedge clk) disable iff (!rst_n)
    swrst |=> (state_q == ST_RESET && !valid_q));
  a_r8_busy_ignore: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q != PH_IDLE && !swrst) |=> $stable(tgt_q));

endmodule

// File: rtl/sereng_op_flags.sv
module sereng_op_flags
  import sereng_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          in_reset,
  input  logic          clr_osvc,
  input  logic          clr_isvc,
  input  logic          nack_evt,
  input  logic          out_svc_evt,
  input  logic          in_svc_evt,
  input  logic          out_done_evt,
  input  logic          in_done_evt,
  input  logic          out_nempty_lvl,
  input  logic          in_nempty_lvl,
  input  logic          out_full_lvl,
  output logic [DW-1:0] flags_o
);

  logic nack_q, osvc_q, isvc_q, odone_q, idone_q;
  logic [2:0] occ_q;

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      nack_q  <= 1'b0;
      osvc_q  <= 1'b0;
      isvc_q  <= 1'b0;
      odone_q <= 1'b0;
      idone_q <= 1'b0;
      occ_q   <= '0;
    end else begin
      nack_q  <= nack_q  | nack_evt;
      odone_q <= odone_q | out_done_evt;
      idone_q <= idone_q | in_done_evt;
      osvc_q  <= out_svc_evt | (osvc_q & ~clr_osvc);
      isvc_q  <= in_svc_evt  | (isvc_q & ~clr_isvc);
      occ_q   <= {out_full_lvl, in_nempty_lvl, out_nempty_lvl};
    end
  end

  always_comb begin
    flags_o = '0;
    flags_o[FLB_NACK]  = nack_q;
    flags_o[FLB_ONE]   = occ_q[0] & ~in_reset;
    flags_o[FLB_INE]   = occ_q[1] & ~in_reset;
    flags_o[FLB_OFULL] = occ_q[2] & ~in_reset;
    flags_o[FLB_OSVC]  = osvc_q;
    flags_o[FLB_ISVC]  = isvc_q;
    flags_o[FLB_ODONE] = odone_q;
    flags_o[FLB_IDONE] = idone_q;
  end

  a_r6_w1c_out: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_osvc && !out_svc_evt) |=> !osvc_q);
  a_r6_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (in_svc_evt && !flush) |=> isvc_q);
  a_r5_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (nack_q && !flush) |=> nack_q);
  a_r4_flush: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (!osvc_q && !isvc_q && !nack_q && !odone_q && !idone_q));

endmodule

// File: rtl/sereng_regif.sv
module sereng_regif
  import sereng_pkg::*;
#(
  parameter int AW = 3,
  parameter int DW = 32,
  parameter int A_STATE  = 0,
  parameter int A_SWRST  = 1,
  parameter int A_OPFLAG = 2,
  parameter int A_MGEN   = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [AW-1:0] reg_addr,
  input  logic [DW-1:0] reg_wdata,
  input  logic [1:0]    st_code,
  input  logic          st_valid,
  input  logic [DW-1:0] flags_word,
  output logic [DW-1:0] rdata,
  output logic          state_wr,
  output logic          swrst_pulse,
  output logic          clr_osvc,
  output logic          clr_isvc
);

  logic mgen_q;
  logic hit_state, hit_swrst, hit_opflag, hit_mgen;

  assign hit_state  = reg_addr == AW'(A_STATE);
  assign hit_swrst  = reg_addr == AW'(A_SWRST);
  assign hit_opflag = reg_addr == AW'(A_OPFLAG);
  assign hit_mgen   = reg_addr == AW'(A_MGEN);

  assign state_wr    = reg_wr && hit_state;
  assign swrst_pulse = reg_wr && hit_swrst && reg_wdata[0];
  assign clr_osvc    = reg_wr && hit_opflag && reg_wdata[FLB_OSVC];
  assign clr_isvc    = reg_wr && hit_opflag && reg_wdata[FLB_ISVC];

  always_ff @(posedge clk) begin
    if (!rst_n || swrst_pulse) mgen_q <= 1'b0;
    else if (reg_wr && hit_mgen) mgen_q <= reg_wdata[0];
  end

  always_comb begin
    rdata = '0;
    if (hit_state) begin
      rdata[1:0]       = st_code;
      rdata[STB_VALID] = st_valid;
      rdata[STB_MGEN]  = mgen_q;
    end else if (hit_opflag) begin
      rdata = flags_word;
    end
  end

  a_r9_mgen_load: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && hit_mgen) |=> (mgen_q == $past(reg_wdata[0])));
  a_r4_mgen_clear: assert property (@(posedge clk) disable iff (!rst_n)
    swrst_pulse |=> !mgen_q);

endmodule

// File: rtl/sereng_state_ctl.sv
module sereng_state_ctl
  import sereng_pkg::*;
#(
  parameter int AW      = 3,
  parameter int DW      = 32,
  parameter int IF_CYC  = 3,
  parameter int SER_CYC = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [AW-1:0] reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  input  logic          ser_tick,
  input  logic          nack_evt,
  input  logic          out_svc_evt,
  input  logic          in_svc_evt,
  input  logic          out_done_evt,
  input  logic          in_done_evt,
  input  logic          out_nempty_lvl,
  input  logic          in_nempty_lvl,
  input  logic          out_full_lvl
);

  logic          state_wr, swrst_pulse, clr_osvc, clr_isvc;
  logic [1:0]    st_code;
  logic          st_valid;
  logic [DW-1:0] flags_word;

  sereng_regif #(.AW(AW), .DW(DW)) u_regif (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .st_code(st_code), .st_valid(st_valid),
    .flags_word(flags_word), .rdata(reg_rdata), .state_wr(state_wr),
    .swrst_pulse(swrst_pulse), .clr_osvc(clr_osvc), .clr_isvc(clr_isvc)
  );

  sereng_state_seq #(.IF_CYC(IF_CYC), .SER_CYC(SER_CYC)) u_seq (
    .clk(clk), .rst_n(rst_n), .req_wr(state_wr), .req_code(reg_wdata[1:0]),
    .swrst(swrst_pulse), .ser_tick(ser_tick), .state_o(st_code), .valid_o(st_valid)
  );

  sereng_op_flags #(.DW(DW)) u_flags (
    .clk(clk), .rst_n(rst_n), .flush(swrst_pulse), .in_reset(st_code == ST_RESET),
    .clr_osvc(clr_osvc), .clr_isvc(clr_isvc), .nack_evt(nack_evt),
    .out_svc_evt(out_svc_evt), .in_svc_evt(in_svc_evt), .out_done_evt(out_done_evt),
    .in_done_evt(in_done_evt), .out_nempty_lvl(out_nempty_lvl),
    .in_nempty_lvl(in_nempty_lvl), .out_full_lvl(out_full_lvl), .flags_o(flags_word)
  );

  a_r2_wr_no_jump: assert property (@(posedge clk) disable iff (!rst_n)
    (state_wr && !swrst_pulse) |=> $stable(st_code));

endmodule

// File: tb/sereng_state_ctl_tb_top.sv
module sereng_state_ctl_tb_top;
  localparam int AW = 3, DW = 32, IFC = 3, SERC = 3;

  logic clk = 0, rst_n = 0, reg_wr = 0, ser_tick = 0;
  logic [AW-1:0] reg_addr = '0;
  logic [DW-1:0] reg_wdata = '0, reg_rdata;
  logic [4:0] evts = '0;
  logic [2:0] lvls = '0;
  int n_chk = 0, n_err = 0;
  logic [1:0] cur_st = 0;
  logic cur_mgen = 0;

  always #5 clk = ~clk;

  sereng_state_ctl #(.AW(AW), .DW(DW), .IF_CYC(IFC), .SER_CYC(SERC)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ser_tick(ser_tick),
    .nack_evt(evts[0]), .out_svc_evt(evts[1]), .in_svc_evt(evts[2]),
    .out_done_evt(evts[3]), .in_done_evt(evts[4]),
    .out_nempty_lvl(lvls[0]), .in_nempty_lvl(lvls[1]), .out_full_lvl(lvls[2])
  );

  function automatic int evt_bit(input int i);
    case (i) 0: return 3; 1: return 8; 2: return 9; 3: return 10; default: return 11; endcase
  endfunction

  function automatic logic [31:0] st_word(input logic [1:0] c, input logic v, input logic m);
    return 32'(c) + (v ? 32'd4 : 32'd0) + (m ? 32'd16 : 32'd0);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input int a, output logic [31:0] v);
    reg_addr = AW'(a); #1; v = reg_rdata;
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = AW'(a); reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  // R3 / R8: bench-side count of edges and ticks after the accepting edge
  task automatic run_trans(input logic [1:0] code, input int per, input bit busy_wr);
    logic [31:0] v; int ticks = 0; bit done = 0;
    @(negedge clk); reg_wr = 1; reg_addr = 0; reg_wdata = 32'(code);
    @(negedge clk); reg_wr = 0;
    rd(0, v); check("R3 valid drops", v, st_word(cur_st, 0, cur_mgen));
    for (int e = 1; e <= 60 && !done; e++) begin
      ser_tick = (e % per) == 0;
      if (busy_wr && e == 1) begin
        reg_wr = 1; reg_addr = 0; reg_wdata = (code == 2'd3) ? 32'd1 : 32'd3;
      end
      @(negedge clk); reg_wr = 0;
      if (e > IFC && ser_tick) ticks++;
      rd(0, v);
      if (ticks == SERC) begin
        done = 1;
        check(busy_wr ? "R8 busy write ignored" : "R3 arrival", v, st_word(code, 1, cur_mgen));
      end else check("R3 window", v, st_word(cur_st, 0, cur_mgen));
    end
    if (!done) check("R3 never completed", 0, 1);
    cur_st = code; ser_tick = 0;
  endtask

  task automatic wait_swrst_done;
    logic [31:0] v;
    ser_tick = 1;
    for (int e = 1; e <= IFC + SERC; e++) begin
      @(negedge clk); rd(0, v);
      check("R4 relatch", v, st_word(2'd0, e == IFC + SERC, 0));
    end
    ser_tick = 0; cur_st = 0; cur_mgen = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] v, expf;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    rd(0, v); check("R1 state reset", v, 32'h4);
    rd(2, v); check("R1 flags reset", v, 0);
    for (int a = 4; a < 8; a++) begin rd(a, v); check("R10 unmapped", v, 0); end

    // R2: illegal code 2
    wr(0, 2);
    for (int i = 0; i < 4; i++) begin rd(0, v); check("R2 code 2 ignored", v, 32'h4); @(negedge clk); end

    // R3 sweep over legal transitions and tick patterns
    run_trans(2'd1, 1, 0);
    run_trans(2'd3, 2, 0);
    run_trans(2'd1, 3, 0);
    run_trans(2'd0, 1, 0);
    run_trans(2'd3, 3, 0);
    run_trans(2'd0, 2, 0);
    run_trans(2'd1, 1, 1);  // R8
    run_trans(2'd3, 1, 1);  // R8

    // R9 master generator
    wr(3, 1); cur_mgen = 1; rd(0, v); check("R9 mgen set", v, st_word(cur_st, 1, 1));
    wr(3, 0); cur_mgen = 0; rd(0, v); check("R9 mgen clear", v, st_word(cur_st, 1, 0));
    wr(3, 1); cur_mgen = 1;
    run_trans(2'd1, 1, 0);

    // R5 sticky events
    expf = 0;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk); evts = 5'(1 << i);
      @(negedge clk); evts = 0;
      expf |= 32'(1) << evt_bit(i);
      rd(2, v); check("R5 event flag", v, expf);
    end
    // R6 write-one-to-clear
    wr(2, 32'hFFFF_FFFF); expf &= ~32'h300;
    rd(2, v); check("R6 w1c service only", v, expf);
    @(negedge clk); evts = 5'b00010; reg_wr = 1; reg_addr = 2; reg_wdata = 32'h100;
    @(negedge clk); evts = 0; reg_wr = 0; expf |= 32'h100;
    rd(2, v); check("R6 set wins", v, expf);

    // R7 occupancy sweep in run state
    for (int c = 0; c < 8; c++) begin
      @(negedge clk); lvls = 3'(c);
      @(negedge clk); rd(2, v); check("R7 levels in run", v, expf | (32'(c) << 4));
    end

    // R4 software reset
    @(negedge clk); reg_wr = 1; reg_addr = 1; reg_wdata = 1;
    @(negedge clk); reg_wr = 0;
    rd(0, v); check("R4 state forced", v, st_word(0, 0, 0));
    rd(2, v); check("R4 flags flushed", v, 0);
    wait_swrst_done();
    for (int c = 0; c < 8; c++) begin
      @(negedge clk); lvls = 3'(c);
      @(negedge clk); rd(2, v); check("R7 masked in reset", v, 0);
    end
    lvls = 0;

    // R4 abort of a pending transition
    run_trans(2'd1, 1, 0);
    @(negedge clk); reg_wr = 1; reg_addr = 0; reg_wdata = 3;
    @(negedge clk); reg_wr = 1; reg_addr = 1; reg_wdata = 1;
    @(negedge clk); reg_wr = 0;
    rd(0, v); check("R4 abort", v, st_word(0, 0, 0));
    wait_swrst_done();

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule